// File: doc/BRIEF.md
# Oversampled UART Frame Engine

This block is the serial core of a UART: one transmitter and one receiver sharing a single baud-tick source. It runs from a 12 MHz UART clock. A tick is produced every `brd + 1` clocks, and each bit cell is 13 ticks long. The bit rate is therefore the clock divided by `13 × (brd + 1)`, so `brd = 7` gives 115200 bps.

The frame shape is chosen by four static control inputs: 7 or 8 data bits, parity on or off, even or odd parity, and one or two stop bits. The transmitter takes a byte through a valid/ready handshake and shifts it out LSB first on `txd`. The receiver watches `rxd` for a falling edge and confirms the start bit at sample 6 of 13. It samples every later bit at that same point and returns a 10-bit word: data in bits [7:0], the parity-error flag in bit 8 and the framing-error flag in bit 9. Transmit and receive have separate enables. A loopback control feeds the transmit line straight into the receiver.

Top module: `uart_frame_core`

## Requirements
- R1: A bit cell on `txd` lasts exactly 13 × (`brd` + 1) clock cycles.
- R2: `data8` = 1 selects 8 data bits and `data8` = 0 selects 7. In 7-bit frames `rx_word[7]` reads 0.
- R3: With `par_en` = 1, a parity bit follows the data. `par_odd` = 0 makes the count of ones in data plus parity even, and `par_odd` = 1 makes it odd. A received mismatch sets `rx_word[8]`.
- R4: `stop2` = 0 sends one stop bit and `stop2` = 1 sends two, so back-to-back frames start at least 10 or 11 bit cells apart for 8-bit data without parity.
- R5: `rx_word[9]` is set when the first stop bit is sampled low. `rx_valid` pulses for one cycle with each received word.
- R6: While `tx_en` = 0, `tx_ready` stays 0 and no frame is sent.
- R7: While `rx_en` = 0, no reception starts and `rx_valid` stays 0.
- R8: With `loop_en` = 1, the transmitted frame reaches the receiver internally and `txd` stays high.
- R9: After reset, `txd` is high, all status outputs are low, and `tx_ready` follows `tx_en`. `txd` is high whenever no frame is being sent.
- R10: A change of `brd` during a frame has no effect until all frames have finished.
- R11: A low pulse on `rxd` that ends before the middle of the bit cell starts no reception.
- R12: `tx_loading` is high from the accepted handshake until the start bit begins. `tx_active` is high while a frame is being shifted. `rx_active` is high while a frame is being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART clock, 12 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| loop_en | input | 1 | Internal loopback from transmitter to receiver |
| data8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| stop2 | input | 1 | 1 = two stop bits, 0 = one |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| brd | input | 10 | Baud divisor; tick every brd+1 clocks |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_word | output | 10 | Received word: {framing err, parity err, data} |
| rx_valid | output | 1 | One-cycle pulse when rx_word is updated |
| tx_active | output | 1 | Frame being shifted out |
| tx_loading | output | 1 | Byte accepted, waiting for the start bit |
| rx_active | output | 1 | Frame being received |

## Verification
The checker takes for granted that the frame-shape inputs do not change while a frame is in flight and that `tx_valid` stays asserted until accepted. The 7-bit check on `rx_word[7]` relies on `data8` being steady from the stop sample to the `rx_valid` pulse. The stimulus only changes the shape between frames, after waiting for every status output to fall. The one deliberate mid-frame change is to `brd`, which the design must ignore. Receive frames driven by the bench hold each level for a whole number of bit cells, with `brd` at zero.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;
  localparam int unsigned OVS      = 13;
  localparam int unsigned SMP_W    = $clog2(OVS);
  localparam int unsigned MID_SMP  = (OVS - 1) / 2;
  localparam int unsigned MAX_BITS = 12;
  localparam int unsigned CNT_W    = $clog2(MAX_BITS + 1);

  typedef struct packed {
    logic data8;
    logic stop2;
    logic par_en;
    logic par_odd;
  } frame_cfg_t;
endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
  parameter int unsigned DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             load_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d, div_q, div_d;

  always_comb begin
    tick_o = (cnt_q >= div_q);
    cnt_d  = tick_o ? '0 : cnt_q + DIV_W'(1);
    div_d  = load_i ? div_i : div_q;   // divisor only follows input between frames
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser
  import uart_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       en_i,
  input  frame_cfg_t cfg_i,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  output logic       ready_o,
  output logic       line_o,
  output logic       active_o,
  output logic       loading_o
);
  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_SHIFT} tx_st_t;

  tx_st_t              st_q, st_d;
  logic [MAX_BITS-1:0] sh_q, sh_d, image;
  logic [CNT_W-1:0]    left_q, left_d, nbits, ndat;
  logic [SMP_W-1:0]    smp_q, smp_d;
  logic [7:0]          dm;

  // Frame image, LSB first: start, data, optional parity, stop ones.
  always_comb begin
    ndat  = cfg_i.data8 ? CNT_W'(8) : CNT_W'(7);
    dm    = cfg_i.data8 ? data_i : {1'b0, data_i[6:0]};
    image = '1;
    image[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (CNT_W'(i) < ndat) image[i+1] = dm[i];
    end
    if (cfg_i.par_en) image[ndat + CNT_W'(1)] = (^dm) ^ cfg_i.par_odd;
    nbits = CNT_W'(2) + ndat + CNT_W'(cfg_i.par_en) + CNT_W'(cfg_i.stop2);
  end

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    left_d = left_q;
    smp_d  = smp_q;
    case (st_q)
      TX_IDLE: begin
        if (en_i && valid_i) begin
          st_d   = TX_WAIT;
          sh_d   = image;
          left_d = nbits;
        end
      end
      TX_WAIT: begin
        if (tick_i) begin
          st_d  = TX_SHIFT;
          smp_d = '0;
        end
      end
      TX_SHIFT: begin
        if (tick_i) begin
          if (smp_q == SMP_W'(OVS - 1)) begin
            smp_d  = '0;
            sh_d   = {1'b1, sh_q[MAX_BITS-1:1]};
            left_d = left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) st_d = TX_IDLE;
          end else begin
            smp_d = smp_q + SMP_W'(1);
          end
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      sh_q   <= '1;
      left_q <= '0;
      smp_q  <= '0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      smp_q  <= smp_d;
    end
  end

  assign ready_o   = en_i && (st_q == TX_IDLE);
  assign loading_o = (st_q == TX_WAIT);
  assign active_o  = (st_q == TX_SHIFT);
  assign line_o    = active_o ? sh_q[0] : 1'b1;
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       data8_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       line_i,
  output logic [9:0] word_o,
  output logic       valid_o,
  output logic       active_o
);
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_st_t;

  rx_st_t           st_q, st_d;
  logic [SMP_W-1:0] smp_q, smp_d;
  logic [2:0]       bidx_q, bidx_d;
  logic [7:0]       dat_q, dat_d;
  logic [9:0]       word_q, word_d;
  logic [1:0]       sync_q;
  logic             pbit_q, pbit_d, last_q, last_d, valid_q, valid_d;
  logic             line, mid, endb, perr;

  assign line = sync_q[1];
  assign mid  = (smp_q == SMP_W'(MID_SMP));
  assign endb = (smp_q == SMP_W'(OVS - 1));
  assign perr = par_en_i && (((^dat_q) ^ pbit_q) != par_odd_i);

  always_comb begin
    st_d    = st_q;
    smp_d   = smp_q;
    bidx_d  = bidx_q;
    dat_d   = dat_q;
    pbit_d  = pbit_q;
    last_d  = last_q;
    word_d  = word_q;
    valid_d = 1'b0;
    if (!en_i) begin
      st_d = RX_IDLE;
      if (tick_i) last_d = line;
    end else if (tick_i) begin
      last_d = line;
      smp_d  = endb ? '0 : smp_q + SMP_W'(1);
      case (st_q)
        RX_IDLE: begin
          smp_d = '0;
          if (last_q && !line) begin
            st_d  = RX_START;
            smp_d = SMP_W'(1);
          end
        end
        RX_START: begin
          if (mid && line) st_d = RX_IDLE;           // start not confirmed
          else if (endb) begin
            st_d   = RX_DATA;
            bidx_d = '0;
            dat_d  = '0;
          end
        end
        RX_DATA: begin
          if (mid) dat_d[bidx_q] = line;
          if (endb) begin
            if (bidx_q == (data8_i ? 3'd7 : 3'd6))
              st_d = par_en_i ? RX_PAR : RX_STOP;
            else
              bidx_d = bidx_q + 3'd1;
          end
        end
        RX_PAR: begin
          if (mid) pbit_d = line;
          if (endb) st_d = RX_STOP;
        end
        RX_STOP: begin
          if (mid) begin
            word_d  = {~line, perr, dat_q};
            valid_d = 1'b1;
            st_d    = RX_IDLE;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      st_q    <= RX_IDLE;
      smp_q   <= '0;
      bidx_q  <= '0;
      dat_q   <= '0;
      pbit_q  <= 1'b0;
      last_q  <= 1'b1;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], line_i};
      st_q    <= st_d;
      smp_q   <= smp_d;
      bidx_q  <= bidx_d;
      dat_q   <= dat_d;
      pbit_q  <= pbit_d;
      last_q  <= last_d;
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign word_o   = word_q;
  assign valid_o  = valid_q;
  assign active_o = (st_q != RX_IDLE);
endmodule

// File: rtl/uart_frame_core.sv
module uart_frame_core
  import uart_frame_pkg::*;
#(
  parameter int unsigned DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             loop_en,
  input  logic             data8,
  input  logic             stop2,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic [DIV_W-1:0] brd,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic             rxd,
  output logic             txd,
  output logic [9:0]       rx_word,
  output logic             rx_valid,
  output logic             tx_active,
  output logic             tx_loading,
  output logic             rx_active
);
  frame_cfg_t cfg;
  logic       tick, tx_line, rx_line, div_load;

  assign cfg      = '{data8: data8, stop2: stop2, par_en: par_en, par_odd: par_odd};
  assign div_load = !tx_active && !tx_loading && !rx_active;
  assign rx_line  = loop_en ? tx_line : rxd;
  assign txd      = loop_en ? 1'b1 : tx_line;

  uart_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_i(brd), .load_i(div_load), .tick_o(tick)
  );

  uart_tx_ser u_tx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(tx_en), .cfg_i(cfg),
    .data_i(tx_data), .valid_i(tx_valid), .ready_o(tx_ready), .line_o(tx_line),
    .active_o(tx_active), .loading_o(tx_loading)
  );

  uart_rx_deser u_rx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(rx_en), .data8_i(data8),
    .par_en_i(par_en), .par_odd_i(par_odd), .line_i(rx_line),
    .word_o(rx_word), .valid_o(rx_valid), .active_o(rx_active)
  );
endmodule

// File: rtl/uart_frame_core_chk.sv
module uart_frame_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       rx_en,
  input logic       loop_en,
  input logic       data8,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic [9:0] rx_word,
  input logic       rx_valid,
  input logic       tx_active,
  input logic       tx_loading,
  input logic       rx_active
);
  p_ready_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_en);

  p_idle_txd_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> txd);

  p_loop_txd_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> txd);

  p_rx_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_active && !rx_valid));

  p_bit7_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !data8) |-> !rx_word[7]);

  p_accept_loads_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (tx_loading && !tx_active));

  p_status_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_loading, tx_active}));
endmodule

bind uart_frame_core uart_frame_core_chk u_chk (.*);

// File: tb/test_uart_frame_core.sv
`timescale 1ns/1ps
module test_uart_frame_core;
  logic       clk = 1'b0;
  logic       rst_n, tx_en, rx_en, loop_en, data8, stop2, par_en, par_odd;
  logic [9:0] brd;
  logic [7:0] tx_data;
  logic       tx_valid, tx_ready, rxd, txd, rx_valid, tx_active, tx_loading, rx_active;
  logic [9:0] rx_word;
  logic       ext_wire, rx_drive;

  int total = 0, bad = 0, rx_cnt = 0, cyc = 0;
  logic [9:0] rx_last = '0;

  always #2.5 clk = ~clk;
  assign rxd = ext_wire ? txd : rx_drive;

  uart_frame_core i_uart_frame_core (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .loop_en(loop_en),
    .data8(data8), .stop2(stop2), .par_en(par_en), .par_odd(par_odd), .brd(brd),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .rxd(rxd),
    .txd(txd), .rx_word(rx_word), .rx_valid(rx_valid), .tx_active(tx_active),
    .tx_loading(tx_loading), .rx_active(rx_active)
  );

  // {data8, stop2, par_en, par_odd, brd[3:0], byte[7:0]}
  localparam logic [15:0] VEC [6] = '{16'h80A5, 16'h01FF, 16'hA03C,
                                      16'hF281, 16'h6055, 16'h31C6};

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt  = rx_cnt + 1;
      rx_last = rx_word;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic d8, s2, pe, po, input int b);
    data8 = d8; stop2 = s2; par_en = pe; par_odd = po; brd = 10'(b);
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((tx_active || tx_loading || rx_active) && n < 5000) begin
      @(negedge clk); n++;
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    tx_data = b; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_fall();
    int n = 0;
    while (txd && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic low_run(output int n);
    n = 0;
    while (!txd && n < 3000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_rx(input int prev);
    int n = 0;
    while (rx_cnt == prev && n < 4000) begin @(negedge clk); n++; end
  endtask

  task automatic drive_rx(input logic [11:0] bits, input int nb);
    for (int i = 0; i < nb; i++) begin
      rx_drive = bits[i];
      repeat (13) @(negedge clk);
    end
    rx_drive = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    int prev, n, p;
    logic [15:0] e;
    logic [7:0]  exp_d;
    rst_n = 1'b0; tx_en = 1'b1; rx_en = 1'b1; loop_en = 1'b0;
    tx_valid = 1'b0; tx_data = '0; ext_wire = 1'b1; rx_drive = 1'b1;
    set_cfg(1, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 txd after reset", int'(txd), 1);
    chk("R9 status after reset", int'({tx_active, tx_loading, rx_active, rx_valid}), 0);
    chk("R9 tx_ready follows tx_en", int'(tx_ready), 1);

    // Table walk: txd looped to rxd outside the block
    for (int v = 0; v < 6; v++) begin
      e = VEC[v];
      set_cfg(e[15], e[14], e[13], e[12], int'(e[11:8]));
      wait_idle();
      p = 13 * (int'(e[11:8]) + 1);
      prev = rx_cnt;
      send_byte(e[7:0]);
      chk("R12 loading after accept", int'({tx_loading, tx_active}), 2);
      wait_fall();
      low_run(n);
      if (e[0]) chk("R1 start bit width", n, p);
      chk("R12 rx_active mid frame", int'(rx_active), 1);
      wait_rx(prev);
      exp_d = e[15] ? e[7:0] : {1'b0, e[6:0]};
      chk("R2 R3 received word", int'(rx_last), int'({2'b00, exp_d}));
      chk("R5 one pulse per frame", rx_cnt, prev + 1);
    end

    // R10: divisor changed mid-frame is ignored until the boundary
    set_cfg(1, 0, 0, 0, 1);
    wait_idle();
    prev = rx_cnt;
    send_byte(8'h00);
    wait_fall();
    n = 0;
    while (!txd && n < 3000) begin
      n++;
      if (n == 3) brd = 10'd3;
      @(negedge clk);
    end
    chk("R10 old divisor holds in frame", n, 9 * 26);
    wait_rx(prev);
    chk("R10 word with old divisor", int'(rx_last), 0);
    wait_idle();
    send_byte(8'h01);
    wait_fall();
    low_run(n);
    chk("R10 new divisor after boundary", n, 52);
    wait_idle();

    // R4: back-to-back frame spacing
    for (int s = 0; s < 2; s++) begin
      set_cfg(1, s[0], 0, 0, 0);
      wait_idle();
      tx_data = 8'hFF; tx_valid = 1'b1;
      wait_fall();
      n = 0;
      while (!txd && n < 3000) begin n++; @(negedge clk); end
      while (txd && n < 3000) begin n++; @(negedge clk); end
      tx_valid = 1'b0;
      chk("R4 frame spacing in range",
          int'(n >= 13 * (10 + s) && n < 13 * (11 + s)), 1);
      wait_idle();
    end

    // R3: transmitted parity bit value at mid cell
    for (int po = 0; po < 2; po++) begin
      set_cfg(1, 0, 1, po[0], 0);
      wait_idle();
      send_byte(8'h03);
      wait_fall();
      repeat (13 * 9 + 6) @(negedge clk);
      chk("R3 tx parity bit", int'(txd), po);
      wait_idle();
    end

    // Receiver driven directly by the bench, brd = 0
    ext_wire = 1'b0;
    set_cfg(1, 0, 1, 0, 0);
    wait_idle();
    prev = rx_cnt;
    drive_rx({1'b1, 1'b1, 1'b1, 1'b0, 8'h07, 1'b0}, 11);
    chk("R3 bad even parity flagged", int'(rx_last), 10'h107);
    prev = rx_cnt;
    drive_rx({1'b1, 1'b1, 1'b1, 1'b1, 8'h07, 1'b0}, 11);
    chk("R3 good parity clear", int'(rx_last), 10'h007);

    set_cfg(1, 0, 0, 0, 0);
    drive_rx({3'b111, 1'b0, 8'h5A, 1'b0}, 10);
    chk("R5 stop low sets framing flag", int'(rx_last), 10'h25A);

    // R7: receive disabled
    rx_en = 1'b0;
    prev = rx_cnt;
    drive_rx({3'b111, 1'b1, 8'h5A, 1'b0}, 10);
    chk("R7 no word while disabled", rx_cnt, prev);
    chk("R7 rx_active low while disabled", int'(rx_active), 0);
    rx_en = 1'b1;
    repeat (20) @(negedge clk);

    // R11: short glitch
    prev = rx_cnt;
    rx_drive = 1'b0;
    repeat (3) @(negedge clk);
    rx_drive = 1'b1;
    repeat (200) @(negedge clk);
    chk("R11 glitch gives no word", rx_cnt, prev);
    chk("R11 receiver back to idle", int'(rx_active), 0);

    // R6: transmit disabled
    ext_wire = 1'b1;
    tx_en = 1'b0;
    tx_data = 8'h00; tx_valid = 1'b1;
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tx_ready || !txd || tx_active) n++;
    end
    tx_valid = 1'b0;
    chk("R6 nothing sent while disabled", n, 0);
    tx_en = 1'b1;
    repeat (5) @(negedge clk);

    // R8: loopback
    ext_wire = 1'b0; rx_drive = 1'b1; loop_en = 1'b1;
    wait_idle();
    prev = rx_cnt;
    send_byte(8'h96);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      if (!txd) n++;
      @(negedge clk);
    end
    chk("R8 txd held high in loopback", n, 0);
    chk("R8 loopback word", int'(rx_last), 10'h096);
    chk("R8 loopback one word", rx_cnt, prev + 1);
    loop_en = 1'b0;
    wait_idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule